// File: doc/BRIEF.md
# Hamming-Corrected Single-Port RAM with Self-Test

This block wraps a synchronous single-port memory with single-error correction. Every word written through the user port is extended with Hamming check bits, so a 16-bit word is stored as a 21-bit codeword. Every read recomputes the syndrome and flips the one bit that the syndrome points at before the data leaves the block. A sticky correction flag records that a nonzero syndrome has been seen. The flag therefore acts as a signature that a stored bit was upset. A separate write control stores a raw codeword exactly as supplied. Test logic can use it to plant single-bit faults and exercise the corrector.

A built-in self-test engine starts on a single-cycle pulse. It writes an address-dependent pattern to every word and reads every word back through the corrector. It then does the same with the complement of the pattern, and finally reports done and pass/fail on status outputs. While the engine runs, the block shows busy and the user port is locked out. The whole test takes four passes over the array, which stays far inside a one-second test budget for any practical depth.

Top module: `hamming_ram_bist`

## Requirements
- R1: A user write stores a codeword of DATA_W + CHK_W bits, using 1-based positions 1 to CW_W, where CHK_W is the smallest r with 2^r >= DATA_W + r + 1 (5 check bits for 16 data bits, 21-bit codeword). Check bit p sits at position 2^p (codeword bit index 2^p - 1) and is the XOR of every other position whose index has bit p set. The data bits fill the non-power-of-two positions in ascending order, LSB first. Reading back an unmodified codeword, whether written through the encoder or stored raw, returns the original data and does not set the correction flag.
- R2: When a stored codeword differs from a valid one in any single bit position, a read returns the corrected data.
- R3: A read accepted at a clock edge (usr_en=1, usr_we=0, raw_we=0, not busy) presents its data on usr_rdata with usr_rvalid=1 right after that edge. usr_rvalid is 1 for exactly one cycle per accepted read and is 0 after reset.
- R4: corr_flag is 0 after reset. It becomes 1 after any read, user or self-test, whose syndrome is nonzero, and then stays 1. If a nonzero-syndrome read and sts_clr fall in the same cycle, the set wins.
- R5: A cycle with sts_clr=1 and no nonzero-syndrome read clears corr_flag.
- R6: A one-cycle pulse on bist_start while the engine is idle raises bist_busy right after that edge. bist_busy stays high for exactly 4*2^ADDR_W cycles, after which bist_done=1, bist_busy=0 and bist_pass=1 for a fault-free array. All three outputs are 0 after reset, and bist_pass is 0 whenever bist_done is 0.
- R7: While bist_busy=1, user reads produce no usr_rvalid, and user and raw writes do not change memory contents.
- R8: The self-test uses the pattern P(a) = a zero-extended to DATA_W, XOR a constant whose odd-numbered bits are 1 (0xAAAA for 16 bits). It writes P(a) to all words, reads all words back, writes ~P(a) to all words and reads all words back. Any word that mismatches after correction makes bist_pass 0. After a completed test, word a holds ~P(a).
- R9: A new bist_start after completion clears bist_done and restarts the test. A bist_start while busy is ignored and does not lengthen the run.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| usr_en | input | 1 | User access request |
| usr_we | input | 1 | 1 = write, 0 = read (with usr_en) |
| usr_addr | input | ADDR_W | Word address for user and raw access |
| usr_wdata | input | DATA_W | Write data to be encoded |
| raw_we | input | 1 | Store raw_cw unencoded at usr_addr |
| raw_cw | input | CW_W | Raw codeword for raw_we |
| usr_rdata | output | DATA_W | Corrected read data |
| usr_rvalid | output | 1 | usr_rdata carries a fresh read |
| sts_clr | input | 1 | Write to status: clears corr_flag |
| corr_flag | output | 1 | Sticky: a nonzero syndrome was seen |
| bist_start | input | 1 | One-cycle start pulse for the self-test |
| bist_busy | output | 1 | Self-test in progress |
| bist_done | output | 1 | Self-test finished |
| bist_pass | output | 1 | Self-test finished with no mismatch |

## Verification
The bench builds the block with DATA_W=16 and ADDR_W=4. That gives the 21-bit codeword with 5 check bits and a 16-word array whose full self-test lasts 64 cycles. The short run lets the bench count the busy window exactly and place an ignored restart, an ignored write and an ignored read at chosen phases of the test. The 21-bit codeword lets every single bit position be flipped through the raw write and corrected in turn.

// File: rtl/hram_pkg.sv
package hram_pkg;

    // Smallest number of Hamming check bits covering dw data bits
    function automatic int chk_width(input int dw);
        for (int r = 1; r < 31; r++) begin
            if ((1 << r) >= dw + r + 1) return r;
        end
        return 31;
    endfunction

    typedef enum logic [1:0] {B_IDLE, B_RUN, B_DONE} bist_st_e;
    typedef enum logic [1:0] {PH_WR_A, PH_RD_A, PH_WR_B, PH_RD_B} bist_ph_e;

endpackage

// File: rtl/hram_encoder.sv
module hram_encoder #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = hram_pkg::chk_width(DATA_W),
    parameter int CW_W   = DATA_W + CHK_W
) (
    input  logic [DATA_W-1:0] data_i,
    output logic [CW_W-1:0]   cw_o
);

    always_comb begin
        logic [CW_W-1:0] cw;
        int   j;
        logic par;
        cw = '0;
        j  = 0;
        // scatter data over non-power-of-two positions
        for (int pos = 1; pos <= CW_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                cw[pos-1] = data_i[j];
                j++;
            end
        end
        // check bit p covers every position with bit p set
        for (int p = 0; p < CHK_W; p++) begin
            par = 1'b0;
            for (int pos = 1; pos <= CW_W; pos++) begin
                if (((pos >> p) & 1) == 1 && pos != (1 << p)) par ^= cw[pos-1];
            end
            cw[(1 << p) - 1] = par;
        end
        cw_o = cw;
    end

endmodule

// File: rtl/hram_decoder.sv
module hram_decoder #(
    parameter int DATA_W = 16,
    parameter int CHK_W  = hram_pkg::chk_width(DATA_W),
    parameter int CW_W   = DATA_W + CHK_W
) (
    input  logic [CW_W-1:0]   cw_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o
);

    always_comb begin
        logic [CHK_W-1:0] syn;
        logic [CW_W-1:0]  fixed;
        int               j;
        syn = '0;
        for (int pos = 1; pos <= CW_W; pos++) begin
            if (cw_i[pos-1]) syn ^= CHK_W'(pos);
        end
        fixed = cw_i;
        if (syn != '0 && int'(syn) <= CW_W) fixed[int'(syn)-1] = ~fixed[int'(syn)-1];
        data_o = '0;
        j      = 0;
        for (int pos = 1; pos <= CW_W; pos++) begin
            if ((pos & (pos - 1)) != 0) begin
                data_o[j] = fixed[pos-1];
                j++;
            end
        end
        err_o = (syn != '0);
    end

endmodule

// File: rtl/hram_bist_engine.sv
module hram_bist_engine
    import hram_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [DATA_W-1:0] rd_data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              pass_o,
    output logic              we_o,
    output logic [ADDR_W-1:0] addr_o,
    output logic [DATA_W-1:0] wdata_o
);

    localparam logic [DATA_W-1:0] PAT_K = {(DATA_W/2){2'b10}};

    typedef struct packed {
        bist_st_e          st;
        bist_ph_e          ph;
        logic [ADDR_W-1:0] addr;
        logic              ok;
    } bist_t;

    bist_t s_d, s_q;
    logic [DATA_W-1:0] pat, expv;

    assign pat     = DATA_W'(s_q.addr) ^ PAT_K;
    assign expv    = (s_q.ph == PH_RD_B) ? ~pat : pat;
    assign busy_o  = (s_q.st == B_RUN);
    assign done_o  = (s_q.st == B_DONE);
    assign pass_o  = done_o && s_q.ok;
    assign we_o    = busy_o && (s_q.ph == PH_WR_A || s_q.ph == PH_WR_B);
    assign addr_o  = s_q.addr;
    assign wdata_o = (s_q.ph == PH_WR_B) ? ~pat : pat;

    always_comb begin
        s_d = s_q;
        case (s_q.st)
            B_RUN: begin
                if ((s_q.ph == PH_RD_A || s_q.ph == PH_RD_B) && rd_data_i != expv)
                    s_d.ok = 1'b0;
                s_d.addr = s_q.addr + 1'b1;
                if (s_q.addr == '1) begin
                    if (s_q.ph == PH_RD_B) s_d.st = B_DONE;
                    else                   s_d.ph = bist_ph_e'(s_q.ph + 2'd1);
                end
            end
            default: begin
                if (start_i) begin
                    s_d.st   = B_RUN;
                    s_d.ph   = PH_WR_A;
                    s_d.addr = '0;
                    s_d.ok   = 1'b1;
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.st   <= B_IDLE;
            s_q.ph   <= PH_WR_A;
            s_q.addr <= '0;
            s_q.ok   <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    // R6
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy_o) |-> $past(start_i));
    // R6
    last_read_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && s_q.ph == PH_RD_B && s_q.addr == '1) |=> (done_o && !busy_o));
    // R9
    start_busy_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i && s_q.addr != '1) |=> (busy_o && s_q.addr == $past(s_q.addr) + 1'b1));

endmodule

// File: rtl/hamming_ram_bist.sv
module hamming_ram_bist #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 6,
    localparam int CHK_W = hram_pkg::chk_width(DATA_W),
    localparam int CW_W  = DATA_W + CHK_W,
    localparam int DEPTH = 1 << ADDR_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              usr_en,
    input  logic              usr_we,
    input  logic [ADDR_W-1:0] usr_addr,
    input  logic [DATA_W-1:0] usr_wdata,
    input  logic              raw_we,
    input  logic [CW_W-1:0]   raw_cw,
    output logic [DATA_W-1:0] usr_rdata,
    output logic              usr_rvalid,
    input  logic              sts_clr,
    output logic              corr_flag,
    input  logic              bist_start,
    output logic              bist_busy,
    output logic              bist_done,
    output logic              bist_pass
);

    typedef struct packed {
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              flag;
    } port_t;

    port_t p_d, p_q;

    logic [CW_W-1:0]   mem [DEPTH];
    logic [CW_W-1:0]   enc_cw, mem_wcw, mem_rcw;
    logic [DATA_W-1:0] enc_in, dec_data, b_wdata;
    logic [ADDR_W-1:0] mem_addr, b_addr;
    logic              mem_we, b_we, dec_err, usr_rd, rd_act;

    hram_encoder #(.DATA_W(DATA_W)) u_enc (.data_i(enc_in), .cw_o(enc_cw));
    hram_decoder #(.DATA_W(DATA_W)) u_dec (.cw_i(mem_rcw), .data_o(dec_data), .err_o(dec_err));

    hram_bist_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_bist (
        .clk(clk), .rst_n(rst_n), .start_i(bist_start), .rd_data_i(dec_data),
        .busy_o(bist_busy), .done_o(bist_done), .pass_o(bist_pass),
        .we_o(b_we), .addr_o(b_addr), .wdata_o(b_wdata)
    );

    // port steering: engine owns the array while busy
    always_comb begin
        usr_rd   = !bist_busy && usr_en && !usr_we && !raw_we;
        rd_act   = usr_rd || (bist_busy && !b_we);
        enc_in   = bist_busy ? b_wdata : usr_wdata;
        mem_addr = bist_busy ? b_addr : usr_addr;
        mem_we   = bist_busy ? b_we : (raw_we || (usr_en && usr_we));
        mem_wcw  = (!bist_busy && raw_we) ? raw_cw : enc_cw;
    end

    assign mem_rcw = mem[mem_addr];

    always_ff @(posedge clk) begin
        if (mem_we) mem[mem_addr] <= mem_wcw;
    end

    always_comb begin
        p_d        = p_q;
        p_d.rvalid = usr_rd;
        if (usr_rd) p_d.rdata = dec_data;
        p_d.flag   = (p_q.flag && !sts_clr) || (rd_act && dec_err);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            p_q.rdata  <= '0;
            p_q.rvalid <= 1'b0;
            p_q.flag   <= 1'b0;
        end else begin
            p_q <= p_d;
        end
    end

    assign usr_rdata  = p_q.rdata;
    assign usr_rvalid = p_q.rvalid;
    assign corr_flag  = p_q.flag;

    // R3
    rvalid_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
        usr_rvalid |-> $past(usr_en && !usr_we && !raw_we && !bist_busy));
    // R4
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (corr_flag && !sts_clr) |=> corr_flag);
    // R5
    flag_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sts_clr && !(rd_act && dec_err)) |=> !corr_flag);
    // R7
    busy_no_rvalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bist_busy |=> !usr_rvalid);

endmodule

// File: tb/hamming_ram_bist_tb.sv
module hamming_ram_bist_tb;

    localparam int CLK_PER = 10;
    localparam int DW      = 16;
    localparam int AW      = 4;
    localparam int CK      = 5;
    localparam int CWW     = DW + CK;
    localparam int NW      = 1 << AW;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          usr_en = 1'b0, usr_we = 1'b0, raw_we = 1'b0;
    logic [AW-1:0] usr_addr = '0;
    logic [DW-1:0] usr_wdata = '0;
    logic [CWW-1:0] raw_cw = '0;
    logic [DW-1:0] usr_rdata;
    logic          usr_rvalid, sts_clr = 1'b0, corr_flag;
    logic          bist_start = 1'b0, bist_busy, bist_done, bist_pass;

    int checks = 0;
    int errors = 0;

    always #(CLK_PER/2) clk = ~clk;

    hamming_ram_bist #(.DATA_W(DW), .ADDR_W(AW)) u_dut (
        .clk(clk), .rst_n(rst_n), .usr_en(usr_en), .usr_we(usr_we),
        .usr_addr(usr_addr), .usr_wdata(usr_wdata), .raw_we(raw_we), .raw_cw(raw_cw),
        .usr_rdata(usr_rdata), .usr_rvalid(usr_rvalid), .sts_clr(sts_clr),
        .corr_flag(corr_flag), .bist_start(bist_start), .bist_busy(bist_busy),
        .bist_done(bist_done), .bist_pass(bist_pass)
    );

    function automatic logic [CWW-1:0] ref_enc(input logic [DW-1:0] d);
        logic [CWW-1:0] c;
        int k;
        c = '0; k = 0;
        for (int pos = 1; pos <= CWW; pos++)
            if (!(pos == 1 || pos == 2 || pos == 4 || pos == 8 || pos == 16)) begin
                c[pos-1] = d[k]; k++;
            end
        for (int p = 0; p < CK; p++)
            for (int pos = 1; pos <= CWW; pos++)
                if (pos[p] && pos != (1 << p)) c[(1 << p) - 1] ^= c[pos-1];
        return c;
    endfunction

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, expv);
        end
    endtask

    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d);
        usr_en = 1'b1; usr_we = 1'b1; usr_addr = a; usr_wdata = d;
        @(negedge clk);
        usr_en = 1'b0; usr_we = 1'b0;
    endtask

    task automatic do_raw(input logic [AW-1:0] a, input logic [CWW-1:0] c);
        raw_we = 1'b1; usr_addr = a; raw_cw = c;
        @(negedge clk);
        raw_we = 1'b0;
    endtask

    task automatic do_read(input logic [AW-1:0] a, output logic [DW-1:0] d, output logic v);
        usr_en = 1'b1; usr_we = 1'b0; usr_addr = a;
        @(negedge clk);
        d = usr_rdata; v = usr_rvalid;
        usr_en = 1'b0;
    endtask

    task automatic clear_flag();
        sts_clr = 1'b1;
        @(negedge clk);
        sts_clr = 1'b0;
    endtask

    task automatic t_reset();
        chk(usr_rvalid == 1'b0, "R3 reset rvalid", 32'(usr_rvalid), 0);
        chk(corr_flag == 1'b0, "R4 reset flag", 32'(corr_flag), 0);
        chk(bist_busy == 1'b0, "R6 reset busy", 32'(bist_busy), 0);
        chk(bist_done == 1'b0, "R6 reset done", 32'(bist_done), 0);
        chk(bist_pass == 1'b0, "R6 reset pass", 32'(bist_pass), 0);
    endtask

    task automatic t_write_read();
        logic [DW-1:0] pats [4] = '{16'h0000, 16'hFFFF, 16'h1234, 16'hA5A5};
        logic [AW-1:0] adrs [4] = '{4'd0, 4'd15, 4'd7, 4'd3};
        logic [DW-1:0] d; logic v;
        for (int i = 0; i < 4; i++) do_write(adrs[i], pats[i]);
        for (int i = 0; i < 4; i++) begin
            do_read(adrs[i], d, v);
            chk(d == pats[i], "R1 data round trip", 32'(d), 32'(pats[i]));
            chk(v == 1'b1, "R3 rvalid after read", 32'(v), 1);
            @(negedge clk);
            chk(usr_rvalid == 1'b0, "R3 rvalid one cycle", 32'(usr_rvalid), 0);
        end
        chk(corr_flag == 1'b0, "R1 clean words leave flag clear", 32'(corr_flag), 0);
        do_raw(4'd5, ref_enc(16'hBEEF));
        do_read(4'd5, d, v);
        chk(d == 16'hBEEF, "R1 raw layout decode", 32'(d), 32'hBEEF);
        chk(corr_flag == 1'b0, "R1 raw valid codeword no flag", 32'(corr_flag), 0);
    endtask

    task automatic t_correct();
        logic [DW-1:0] d; logic v;
        for (int b = 0; b < CWW; b++) begin
            clear_flag();
            do_raw(4'd9, ref_enc(16'h3C5A) ^ (CWW'(1) << b));
            do_read(4'd9, d, v);
            chk(d == 16'h3C5A, $sformatf("R2 correct bit %0d", b), 32'(d), 32'h3C5A);
            chk(corr_flag == 1'b1, $sformatf("R4 flag on bit %0d", b), 32'(corr_flag), 1);
        end
    endtask

    task automatic t_flag();
        clear_flag();
        chk(corr_flag == 1'b0, "R5 clear", 32'(corr_flag), 0);
        do_raw(4'd6, ref_enc(16'h00FF) ^ 21'h000400);
        usr_en = 1'b1; usr_we = 1'b0; usr_addr = 4'd6; sts_clr = 1'b1;
        @(negedge clk);
        usr_en = 1'b0; sts_clr = 1'b0;
        chk(corr_flag == 1'b1, "R4 set beats clear", 32'(corr_flag), 1);
        chk(usr_rdata == 16'h00FF, "R2 corrected under clear", 32'(usr_rdata), 32'h00FF);
        @(negedge clk);
        chk(corr_flag == 1'b1, "R4 sticky", 32'(corr_flag), 1);
        clear_flag();
        chk(corr_flag == 1'b0, "R5 clear after set", 32'(corr_flag), 0);
    endtask

    task automatic t_bist();
        logic [DW-1:0] d; logic v;
        int cnt;
        clear_flag();
        bist_start = 1'b1;
        @(negedge clk);
        bist_start = 1'b0;
        cnt = 0;
        while (bist_busy && cnt < 1000) begin
            cnt++;
            @(negedge clk);
        end
        chk(cnt == 4 * NW, "R6 busy length", 32'(cnt), 32'(4 * NW));
        chk(bist_done == 1'b1, "R6 done", 32'(bist_done), 1);
        chk(bist_pass == 1'b1, "R6 pass", 32'(bist_pass), 1);
        chk(corr_flag == 1'b0, "R4 clean test no flag", 32'(corr_flag), 0);
        for (int a = 0; a < NW; a++) begin
            do_read(AW'(a), d, v);
            chk(d == (16'h5555 ^ 16'(a)), "R8 complement left in array", 32'(d), 32'(16'h5555 ^ 16'(a)));
        end
    endtask

    task automatic t_bist_ignore();
        logic [DW-1:0] d; logic v;
        int cnt;
        bist_start = 1'b1;
        @(negedge clk);
        bist_start = 1'b0;
        chk(bist_done == 1'b0, "R9 restart clears done", 32'(bist_done), 0);
        chk(bist_pass == 1'b0, "R6 pass low while not done", 32'(bist_pass), 0);
        cnt = 0;
        while (bist_busy && cnt < 1000) begin
            cnt++;
            bist_start = (cnt == 10);
            usr_en = 1'b0; usr_we = 1'b0;
            if (cnt == 60) begin
                usr_en = 1'b1; usr_we = 1'b1; usr_addr = 4'd2; usr_wdata = 16'h0F0F;
            end
            if (cnt == 61) begin
                usr_en = 1'b1; usr_we = 1'b0; usr_addr = 4'd3;
            end
            if (cnt == 62) chk(usr_rvalid == 1'b0, "R7 no rvalid while busy", 32'(usr_rvalid), 0);
            @(negedge clk);
        end
        bist_start = 1'b0; usr_en = 1'b0; usr_we = 1'b0;
        chk(cnt == 4 * NW, "R9 restart while busy ignored", 32'(cnt), 32'(4 * NW));
        chk(bist_pass == 1'b1, "R6 pass second run", 32'(bist_pass), 1);
        do_read(4'd2, d, v);
        chk(d == 16'h5557, "R7 write during test ignored", 32'(d), 32'h5557);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_write_read();
        t_correct();
        t_flag();
        t_bist();
        t_bist_ignore();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule